// File: doc/BRIEF.md
# Dual-Output Interrupt Steering Controller

The block collects 51 interrupt request lines and drives two processor interrupt outputs: a normal request and a fast request. Each line has its own trigger mode. A level line follows its input, active high or active low. A single-edge line catches a rising or a falling edge. A dual-edge line catches any change of level. Edge captures are sticky and stay pending until software clears them. A per-line select bit sends a pending, enabled line to the fast output when it is 1 and to the normal output when it is 0.

Software reaches the block through a 32-bit register bus. Reads complete one cycle after the request, and an illegal access raises a one-cycle error flag. Every per-line vector is split into a low word, for lines 0 to 31, and a high word at the low address plus 4, for lines 32 to 50. Enable bits and edge captures are changed through separate set and clear addresses, so that no read-modify-write is needed. The trigger sensitivity and the dual-edge choice are fixed at reset values. Only lines 47 to 50 can have their polarity changed.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After reset, the raw, select and enable vectors are zero and both outputs are low. Sensitivity reads back 0x1F07FFF8FFFF (1 = level), dual-edge reads back 0xF800070000 and polarity reads back 0x5F07FFF8FFFF.
- R2: On a level line, the raw bit equals the input when polarity is 1 and the inverted input when polarity is 0. It updates at the clock edge that samples the input.
- R3: On an edge line whose dual-edge bit is 0, polarity 1 captures a rising edge and polarity 0 captures a falling edge. The captured raw bit stays set after the input returns.
- R4: On an edge line whose dual-edge bit is 1, both a rising and a falling input change set the raw bit.
- R5: Writing ones to edge-clear (0xD8 low, 0xDC high) clears those raw bits on edge lines only; level lines are unaffected. An edge arriving in the same cycle as its clear leaves the bit set.
- R6: Writing ones to 0xA0/0xA4 sets enable bits, and writing ones to 0xA8/0xAC clears them. Enable reads back at 0xA0/0xA4.
- R7: A write to select (0x98/0x9C) replaces the addressed half in full. irq_o is the OR of raw & enable & ~select and fiq_o is the OR of raw & enable & select; these vectors read back at 0x80/0x84 and 0x88/0x8C, and raw reads back at 0x90/0x94.
- R8: A write to the polarity high word (0xD4) changes only data bits 15 to 18 (lines 47 to 50). A write to its low word (0xD0) changes nothing and raises the error flag.
- R9: Registers start at byte address 0x80. Reads below 0x80 return zero, and writes below 0x80 change nothing. Both raise the error flag. High-word bits 19 to 31 read as zero and are dropped on write.
- R10: rsp_valid pulses one cycle after each request. rsp_err pulses with it for any of these: an address below 0x80, unmapped or misaligned; a read of 0xA8/0xB8/0xD8 (either half); a write of 0x80/0x88/0x90/0xC0/0xC8/0xE0 (either half); a write of 0xD0. An errored read returns zero. The software trigger words 0xB0/0xB8 read as zero, take writes without effect and raise no error.
- R11: Edge status at 0xE0/0xE4 reads raw & ~sensitivity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 51 | Interrupt request lines, synchronous to clk |
| req_valid | input | 1 | Bus request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Illegal access flag, valid with rsp_valid |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
A wrong trigger decision or a lost capture shows in the raw word read at 0x90/0x94 on the first read after the input edge. The same fault shows on irq_o or fiq_o in the cycle after the edge if the line is enabled. A routing or enable fault flips the outputs right after the configuring write completes, and the status words at 0x80 and 0x88 show it on the next read. Decode faults show as a wrong rsp_err or non-zero data in the response cycle of that same access. Faults in a stored configuration half show when the other half is read back.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
   localparam int unsigned WORD_W = 32;

   // Register slots in address order: slot k sits at BASE + 8*k (low word), +4 (high word)
   typedef enum logic [3:0] {
      RG_IRQ_ST   = 4'd0,
      RG_FIQ_ST   = 4'd1,
      RG_RAW      = 4'd2,
      RG_SEL      = 4'd3,
      RG_EN_SET   = 4'd4,
      RG_EN_CLR   = 4'd5,
      RG_SWI      = 4'd6,
      RG_SWI_CLR  = 4'd7,
      RG_SENSE    = 4'd8,
      RG_DUAL     = 4'd9,
      RG_EVENT    = 4'd10,
      RG_EDGE_CLR = 4'd11,
      RG_EDGE_ST  = 4'd12,
      RG_NONE     = 4'd15
   } reg_id_e;
endpackage

// File: rtl/irq_steer_decode.sv
module irq_steer_decode
   import irq_steer_pkg::*;
#(
   parameter int unsigned    AW   = 8,
   parameter logic [AW-1:0]  BASE = 'h80
) (
   input  logic [AW-1:0] addr_i,
   input  logic          write_i,
   output reg_id_e       id_o,
   output logic          hi_o,
   output logic          bad_o
);
   localparam int unsigned IDX_W = AW - 3;

   if (AW < 7) begin : g_aw_chk
      $error("irq_steer_decode: AW must be at least 7");
   end
   if (BASE[2:0] != 3'b000) begin : g_base_chk
      $error("irq_steer_decode: BASE must be 8-byte aligned");
   end

   logic [AW-1:0]    off;
   logic [IDX_W-1:0] idx;
   logic             unused_off;

   assign off        = addr_i - BASE;
   assign idx        = off[AW-1:3];
   assign unused_off = ^off[2:0];
   assign hi_o       = addr_i[2];

   always_comb begin
      id_o = RG_NONE;
      if (addr_i >= BASE && addr_i[1:0] == 2'b00 && idx <= IDX_W'(12))
         id_o = reg_id_e'(idx[3:0]);
   end

   always_comb begin
      case (id_o)
         RG_NONE:                                 bad_o = 1'b1;
         RG_EN_CLR, RG_SWI_CLR, RG_EDGE_CLR:      bad_o = !write_i;
         RG_IRQ_ST, RG_FIQ_ST, RG_RAW,
         RG_SENSE, RG_DUAL, RG_EDGE_ST:           bad_o = write_i;
         RG_EVENT:                                bad_o = write_i && !addr_i[2];
         default:                                 bad_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/irq_line_detect.sv
module irq_line_detect (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic in_i,
   input  logic sense_i,   // 1 = level
   input  logic dual_i,    // 1 = both edges
   input  logic event_i,   // 1 = high / rising
   input  logic clr_i,     // edge-capture clear strobe
   output logic raw_o
);
   logic lvl_q;
   logic raw_q;
   logic hit;

   always_comb begin
      if (dual_i)       hit = in_i ^ lvl_q;
      else if (event_i) hit = in_i & ~lvl_q;
      else              hit = ~in_i & lvl_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lvl_q <= 1'b0;
         raw_q <= 1'b0;
      end else begin
         lvl_q <= in_i;
         if (sense_i) raw_q <= ~(in_i ^ event_i);
         else         raw_q <= (raw_q & ~clr_i) | hit;
      end
   end

   assign raw_o = raw_q;

   AST_LEVEL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sense_i |=> (raw_o == ($past(in_i) ~^ $past(event_i)))); // R2
   AST_EDGE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sense_i && raw_o && !clr_i) |=> raw_o); // R3
endmodule

// File: rtl/irq_steer_route.sv
module irq_steer_route #(
   parameter int unsigned N_SRC   = 51,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SRC-1:0] raw_i,
   input  logic [N_SRC-1:0] en_i,
   input  logic [N_SRC-1:0] sel_i,
   output logic             irq_o,
   output logic             fiq_o
);
   logic irq_d;
   logic fiq_d;

   assign irq_d = |(raw_i & en_i & ~sel_i);
   assign fiq_d = |(raw_i & en_i & sel_i);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
         end else begin
            irq_o <= irq_d;
            fiq_o <= fiq_d;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign irq_o = irq_d;
      assign fiq_o = fiq_d;
   end
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
   import irq_steer_pkg::*;
#(
   parameter int unsigned   N_SRC       = 51,
   parameter int unsigned   AW          = 8,
   parameter logic [AW-1:0] BASE        = 'h80,
   parameter logic [63:0]   SENSE_RST   = 64'h0000_1F07_FFF8_FFFF,
   parameter logic [63:0]   DUAL_RST    = 64'h0000_00F8_0007_0000,
   parameter logic [63:0]   EVENT_RST   = 64'h0000_5F07_FFF8_FFFF,
   parameter logic [63:0]   EVENT_WMASK = 64'h0007_8000_0000_0000,
   parameter bit            REG_OUT     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [AW-1:0]     req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              irq_o,
   output logic              fiq_o
);
   localparam int unsigned HI_W  = N_SRC - WORD_W;
   localparam int unsigned PAD_W = 2 * WORD_W - N_SRC;
   localparam logic [N_SRC-1:0] HI_MASK = {{HI_W{1'b1}}, {WORD_W{1'b0}}};
   localparam logic [N_SRC-1:0] SENSE_V = SENSE_RST[N_SRC-1:0];
   localparam logic [N_SRC-1:0] DUAL_V  = DUAL_RST[N_SRC-1:0];
   localparam logic [N_SRC-1:0] EVT_WM  = EVENT_WMASK[N_SRC-1:0];

   if (N_SRC <= WORD_W || N_SRC >= 2 * WORD_W) begin : g_nsrc_chk
      $error("irq_steer_ctrl: N_SRC must lie strictly between one and two words");
   end

   reg_id_e          id;
   logic             hi;
   logic             bad;
   logic             wr_ok;
   logic [2*WORD_W-1:0] w64;
   logic [N_SRC-1:0] wvec;
   logic [N_SRC-1:0] half_mask;
   logic [N_SRC-1:0] sel_q, en_q, evt_q;
   logic [N_SRC-1:0] raw;
   logic [N_SRC-1:0] clr_v;
   logic [N_SRC-1:0] rvec;
   logic [WORD_W-1:0] rword;
   logic             unused_hi_bits;

   irq_steer_decode #(.AW(AW), .BASE(BASE)) u_dec (
      .addr_i  (req_addr),
      .write_i (req_write),
      .id_o    (id),
      .hi_o    (hi),
      .bad_o   (bad)
   );

   assign wr_ok          = req_valid && req_write && !bad;
   assign w64            = hi ? {req_wdata, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, req_wdata};
   assign wvec           = w64[N_SRC-1:0];
   assign unused_hi_bits = ^w64[2*WORD_W-1:N_SRC];
   assign half_mask      = hi ? HI_MASK : ~HI_MASK;
   assign clr_v          = (wr_ok && id == RG_EDGE_CLR) ? wvec : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         en_q  <= '0;
         evt_q <= EVENT_RST[N_SRC-1:0];
      end else if (wr_ok) begin
         case (id)
            RG_SEL:    sel_q <= (sel_q & ~half_mask) | wvec;
            RG_EN_SET: en_q  <= en_q | wvec;
            RG_EN_CLR: en_q  <= en_q & ~wvec;
            RG_EVENT:  evt_q <= (evt_q & ~EVT_WM) | (wvec & EVT_WM);
            default: ;
         endcase
      end
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_line
      irq_line_detect u_det (
         .clk_i   (clk),
         .rst_ni  (rst_n),
         .in_i    (irq_in[i]),
         .sense_i (SENSE_V[i]),
         .dual_i  (DUAL_V[i]),
         .event_i (evt_q[i]),
         .clr_i   (clr_v[i]),
         .raw_o   (raw[i])
      );
   end

   always_comb begin
      case (id)
         RG_IRQ_ST:  rvec = raw & en_q & ~sel_q;
         RG_FIQ_ST:  rvec = raw & en_q & sel_q;
         RG_RAW:     rvec = raw;
         RG_SEL:     rvec = sel_q;
         RG_EN_SET:  rvec = en_q;
         RG_SENSE:   rvec = SENSE_V;
         RG_DUAL:    rvec = DUAL_V;
         RG_EVENT:   rvec = evt_q;
         RG_EDGE_ST: rvec = raw & ~SENSE_V;
         default:    rvec = '0;
      endcase
   end

   assign rword = hi ? {{PAD_W{1'b0}}, rvec[N_SRC-1:WORD_W]} : rvec[WORD_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_rdata <= (req_valid && !req_write && !bad) ? rword : '0;
         rsp_err   <= req_valid && bad;
      end
   end

   irq_steer_route #(.N_SRC(N_SRC), .REG_OUT(REG_OUT)) u_route (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .raw_i  (raw),
      .en_i   (en_q),
      .sel_i  (sel_q),
      .irq_o  (irq_o),
      .fiq_o  (fiq_o)
   );

   AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R10
   AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid); // R10
   AST_BELOW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr < BASE) |=> (rsp_err && rsp_rdata == '0)); // R9
   AST_EN_CLR_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && id == RG_EN_CLR && !hi && req_wdata[0]) |=> !en_q[0]); // R6
endmodule

// File: tb/tb_irq_steer_ctrl.sv
module tb_irq_steer_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [50:0] irq_in = '0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        rsp_err;
   logic        irq_o;
   logic        fiq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [31:0] rd;
   logic        er;
   logic        vl;

   always #5 clk = ~clk;

   irq_steer_ctrl dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .irq_o(irq_o), .fiq_o(fiq_o)
   );

   // {address, expected data, expected error}
   localparam logic [40:0] RST_TBL [0:13] = '{
      {8'h80, 32'h0000_0000, 1'b0}, {8'h84, 32'h0000_0000, 1'b0},
      {8'h90, 32'h0000_0000, 1'b0}, {8'h98, 32'h0000_0000, 1'b0},
      {8'hA0, 32'h0000_0000, 1'b0}, {8'hB0, 32'h0000_0000, 1'b0},
      {8'hC0, 32'hFFF8_FFFF, 1'b0}, {8'hC4, 32'h0000_1F07, 1'b0},
      {8'hC8, 32'h0007_0000, 1'b0}, {8'hCC, 32'h0000_00F8, 1'b0},
      {8'hD0, 32'hFFF8_FFFF, 1'b0}, {8'hD4, 32'h0000_5F07, 1'b0},
      {8'hE0, 32'h0000_0000, 1'b0}, {8'h00, 32'h0000_0000, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_rd(input logic [7:0] a);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      rd = rsp_rdata; er = rsp_err; vl = rsp_valid;
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      er = rsp_err; vl = rsp_valid;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 irq_o in reset", {31'b0, irq_o}, 32'h0);
      chk("R1 fiq_o in reset", {31'b0, fiq_o}, 32'h0);
      rst_n = 1'b1;

      // R1 reset values and R9 below-base read, from the table
      for (int k = 0; k < 14; k++) begin
         bus_rd(RST_TBL[k][40:33]);
         chk($sformatf("R1 reset read %h", RST_TBL[k][40:33]), rd, RST_TBL[k][32:1]);
         chk($sformatf("R10 reset err %h", RST_TBL[k][40:33]), {31'b0, er}, {31'b0, RST_TBL[k][0]});
      end

      // R2 level line 0, active high; R6/R7 enable and routing
      irq_in[0] = 1'b1;
      bus_rd(8'h90);  chk("R2 level raw high", rd, 32'h1);
      chk("R7 irq_o gated by enable", {31'b0, irq_o}, 32'h0);
      bus_wr(8'hA0, 32'h1);
      chk("R7 irq_o routed", {30'b0, irq_o, fiq_o}, 32'h2);
      bus_rd(8'hA0);  chk("R6 enable set readback", rd, 32'h1);
      bus_rd(8'h80);  chk("R7 irq status", rd, 32'h1);
      bus_wr(8'h98, 32'h1);
      chk("R7 fiq_o routed", {30'b0, irq_o, fiq_o}, 32'h1);
      bus_rd(8'h88);  chk("R7 fiq status", rd, 32'h1);
      irq_in[0] = 1'b0;
      bus_rd(8'h90);  chk("R2 level raw follows low", rd, 32'h0);
      chk("R2 fiq_o drops", {31'b0, fiq_o}, 32'h0);
      bus_wr(8'hA8, 32'h1);
      bus_rd(8'hA0);  chk("R6 enable clear", rd, 32'h0);
      bus_wr(8'h98, 32'h0);

      // R3 single-edge: line 46 rising, line 45 falling
      irq_in[46] = 1'b1;
      bus_rd(8'h94);  chk("R3 rising capture", rd, 32'h4000);
      irq_in[46] = 1'b0;
      bus_rd(8'h94);  chk("R3 sticky after input drops", rd, 32'h4000);
      irq_in[45] = 1'b1;
      bus_rd(8'h94);  chk("R3 falling line ignores rise", rd, 32'h4000);
      irq_in[45] = 1'b0;
      bus_rd(8'h94);  chk("R3 falling capture", rd, 32'h6000);
      bus_rd(8'hE4);  chk("R11 edge status high", rd, 32'h6000);

      // R5 edge clear; level line unaffected
      bus_wr(8'hDC, 32'h6000);
      bus_rd(8'h94);  chk("R5 edge clear", rd, 32'h0);
      irq_in[0] = 1'b1;
      bus_wr(8'hD8, 32'h1);
      bus_rd(8'h90);  chk("R5 clear ignores level line", rd, 32'h1);
      bus_rd(8'hE0);  chk("R11 edge status excludes level", rd, 32'h0);
      irq_in[0] = 1'b0;

      // R4 dual-edge line 16
      irq_in[16] = 1'b1;
      bus_rd(8'h90);  chk("R4 dual rise", rd, 32'h1_0000);
      bus_wr(8'hD8, 32'h1_0000);
      bus_rd(8'h90);  chk("R5 dual cleared", rd, 32'h0);
      irq_in[16] = 1'b0;
      bus_rd(8'h90);  chk("R4 dual fall", rd, 32'h1_0000);
      bus_wr(8'hD8, 32'h1_0000);

      // R8 polarity writes
      bus_wr(8'hD0, 32'h0);
      chk("R8 low polarity write error", {31'b0, er}, 32'h1);
      bus_rd(8'hD0);  chk("R8 low polarity unchanged", rd, 32'hFFF8_FFFF);
      bus_wr(8'hD4, 32'hFFFF_FFFF);
      chk("R8 high polarity write ok", {31'b0, er}, 32'h0);
      bus_rd(8'hD4);  chk("R8 only lines 47-50 change", rd, 32'h0007_DF07);
      irq_in[47] = 1'b1;
      bus_rd(8'h94);  chk("R8 line 47 now rising", rd, 32'h8000);
      bus_wr(8'hDC, 32'h8000);
      bus_wr(8'hD4, 32'h0);
      bus_rd(8'hD4);  chk("R8 polarity restored", rd, 32'h0000_5F07);

      // R5 clear and edge in the same cycle: edge wins
      @(negedge clk);
      irq_in[46] = 1'b1;
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'hDC; req_wdata = 32'h4000;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      bus_rd(8'h94);  chk("R5 edge beats clear", rd, 32'h4000);

      // R7 select half replace, R9 high-word masking
      bus_wr(8'h9C, 32'hFFFF_FFFF);
      bus_rd(8'h9C);  chk("R9 high word masked", rd, 32'h0007_FFFF);
      bus_wr(8'h98, 32'h0000_AAAA);
      bus_rd(8'h98);  chk("R7 select low replaced", rd, 32'h0000_AAAA);
      bus_rd(8'h9C);  chk("R7 select high kept", rd, 32'h0007_FFFF);
      bus_wr(8'h98, 32'h0);
      bus_wr(8'h9C, 32'h0);

      // R9/R10 illegal accesses
      bus_wr(8'h10, 32'hFFFF_FFFF);
      chk("R9 below-base write error", {31'b0, er}, 32'h1);
      bus_rd(8'hA8);
      chk("R10 write-only read error", {31'b0, er}, 32'h1);
      chk("R10 write-only read zero", rd, 32'h0);
      chk("R10 response valid", {31'b0, vl}, 32'h1);
      bus_wr(8'h94, 32'h0);
      chk("R10 read-only write error", {31'b0, er}, 32'h1);
      bus_rd(8'h94);  chk("R10 raw unchanged by write", rd, 32'h4000);
      bus_rd(8'hF0);  chk("R10 unmapped read error", {31'b0, er}, 32'h1);
      bus_rd(8'h81);  chk("R10 misaligned read error", {31'b0, er}, 32'h1);
      bus_wr(8'hB0, 32'hFFFF_FFFF);
      chk("R10 software write no error", {31'b0, er}, 32'h0);
      bus_rd(8'hB0);  chk("R10 software reads zero", rd, 32'h0);
      chk("R10 no irq from software write", {30'b0, irq_o, fiq_o}, 32'h0);

      // R7 fast routing through the high word
      irq_in[46] = 1'b0;
      bus_wr(8'hDC, 32'h4000);
      bus_wr(8'hA4, 32'h4000);
      bus_wr(8'h9C, 32'h4000);
      chk("R7 no output before edge", {30'b0, irq_o, fiq_o}, 32'h0);
      irq_in[46] = 1'b1;
      @(negedge clk);
      chk("R7 high line to fiq_o", {30'b0, irq_o, fiq_o}, 32'h1);
      bus_wr(8'h9C, 32'h0);
      chk("R7 high line to irq_o", {30'b0, irq_o, fiq_o}, 32'h2);
      bus_rd(8'h84);  chk("R7 irq status high", rd, 32'h4000);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule